// File: doc/BRIEF.md
# Floating-Point Normalise, Round and Pack Unit

This block sits at the tail of a single-precision floating-point datapath. It receives the raw result of an arithmetic step: a sign, a signed unbiased exponent, a 28-bit unsigned mantissa and a rounding-mode select. It returns the packed 32-bit word with a valid strobe. The mantissa carries two headroom bits above the hidden-bit position and two guard bits below the 23 fraction bits. Its value is `in_mant * 2^(in_exp - 25)`, so bit 25 has weight 1.0.

The work is split over a fixed two-stage pipeline. In the NORMALISE stage, a leading-zero counter and a barrel shifter move the leading one to bit 25 in one step, whichever direction the shift goes. The exponent is corrected to match, and any ones shifted off the bottom are collected into a sticky bit. An all-zero mantissa takes a bypass flag instead.

In the ROUND/PACK stage the result is sorted into one of four result classes: CLS_ZERO, CLS_DENORM, CLS_NORMAL and CLS_INF. This stage shifts tiny values into the denormal range and rounds with the selected mode. If rounding carries the mantissa to 2.0, it renormalises once more. It then biases the exponent and saturates to infinity on overflow. The class is chosen afresh for each valid input, and there is no held state between inputs. The transitions are these:

- any input with a zero mantissa, or with an exponent below -149, goes to CLS_ZERO;
- an exponent below -126 goes to CLS_DENORM;
- a biased exponent above 254 after rounding goes to CLS_INF;
- everything else goes to CLS_NORMAL.

Top module: `fp_norm_round_pack`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` is 0 and `out_word` is 0.
- R2: A result appears on `out_word` with `out_valid` high exactly two clock edges after the edge that samples `in_valid` high; `out_valid` is low in every other cycle.
- R3: A normal result is packed as `{sign, in_exp_normalised + 127 (8 bits), 23 fraction bits}`, with the bit at weight 1.0 dropped. For example, exponent 3 with mantissa 0x3680000 gives 0x415A0000.
- R4: Normalisation shifts the mantissa left when bit 25 is not the leading one, decrementing the exponent once per place. It shifts right when bit 26 or 27 is set, incrementing once per place. Ones shifted off the bottom feed rounding as sticky.
- R5: Mode 2'b00 rounds to nearest, ties to even. With guard bits g[1:0] and sticky s, the retained value is incremented when g[1] and (g[0] or s), or when g==2'b10, s==0 and the retained LSB is 1.
- R6: Mode 2'b01 truncates: the guard bits and sticky never increment the result.
- R7: Mode 2'b10 (toward +infinity) increments the magnitude when any dropped bit is 1 and the sign is 0. Mode 2'b11 (toward -infinity) does so when any dropped bit is 1 and the sign is 1.
- R8: If rounding carries the 24-bit significand to 2.0, the result is shifted right once and the biased exponent is incremented before the overflow check.
- R9: If the biased exponent after rounding exceeds 254, the output is an infinity (exponent 255, fraction 0, input sign) in every rounding mode. A biased exponent of 254 is still a normal result.
- R10: If the normalised exponent is below -126 but not below -149, the significand is shifted right by the shortfall and packed with exponent field 0. The shifted-out bits feed the sticky. If rounding reaches 2^-126, exponent field 1 results.
- R11: An all-zero input mantissa, or a normalised exponent below -149, gives a signed zero (only the sign bit may be 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_sign | input | 1 | Sign of the raw result |
| in_exp | input | 10 | Signed unbiased exponent, two's complement |
| in_mant | input | 28 | Unsigned mantissa, bit 25 has weight 1.0, bits 1:0 are guard |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Packed result valid |
| out_word | output | 32 | Packed single-precision result |

## Verification
The mantissa is offered in three placements: already aligned at bit 25, too small (needing a left shift), and spilling into bits 26 and 27 (needing a right shift). Matching results show that the shift amount and the exponent correction agree in both directions. Guard patterns 01, 10 and 11 are combined with retained LSBs of 0 and 1, with and without sticky, and crossed with all four modes and both signs. This separates tie handling, sticky handling and directional rounding. Exponents at 254/255, at -126/-127 and at -149/-150 probe the borders of the CLS_NORMAL, CLS_INF, CLS_DENORM and CLS_ZERO classes, including a carry that moves a result across each border.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    localparam int FRAC_W  = 23;
    localparam int EXP_W   = 8;
    localparam int GUARD_W = 2;
    localparam int HEAD_W  = 2;
    localparam int EIN_W   = 10;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_UP        = 2'b10,
        RM_DOWN      = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_DENORM = 2'd1,
        CLS_NORMAL = 2'd2,
        CLS_INF    = 2'd3
    } rclass_e;

endpackage

// File: rtl/fpn_lzc.sv
module fpn_lzc #(
    parameter int W  = 28,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                cnt = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/fpn_norm.sv
module fpn_norm #(
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 2,
    parameter int HEAD_W  = 2,
    parameter int EIN_W   = 10,
    localparam int MANT_W = HEAD_W + 1 + FRAC_W + GUARD_W,
    localparam int NM_W   = 1 + FRAC_W + GUARD_W,
    localparam int ENW    = EIN_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sign,
    input  logic signed [EIN_W-1:0] in_exp,
    input  logic [MANT_W-1:0]     in_mant,
    input  logic [1:0]            in_mode,
    output logic                  s1_valid,
    output logic                  s1_sign,
    output logic                  s1_zero,
    output logic signed [ENW-1:0] s1_exp,
    output logic [NM_W-1:0]       s1_nm,
    output logic                  s1_sticky,
    output logic [1:0]            s1_mode
);

    localparam int CW = $clog2(MANT_W + 1);

    logic [CW-1:0]       lz;
    logic [MANT_W-1:0]   shifted;
    logic signed [ENW-1:0] exp_n;
    logic                zero_n;

    fpn_lzc #(.W(MANT_W)) u_lzc (
        .vec (in_mant),
        .cnt (lz)
    );

    always_comb begin
        zero_n  = (in_mant == '0);
        shifted = in_mant << lz;
        exp_n   = $signed({in_exp[EIN_W-1], in_exp}) + ENW'(HEAD_W) - ENW'(lz);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_sign   <= 1'b0;
            s1_zero   <= 1'b0;
            s1_exp    <= '0;
            s1_nm     <= '0;
            s1_sticky <= 1'b0;
            s1_mode   <= 2'b00;
        end else begin
            s1_valid  <= in_valid;
            s1_sign   <= in_sign;
            s1_zero   <= zero_n;
            s1_exp    <= zero_n ? '0 : exp_n;
            s1_nm     <= zero_n ? '0 : shifted[MANT_W-1:HEAD_W];
            s1_sticky <= zero_n ? 1'b0 : |shifted[HEAD_W-1:0];
            s1_mode   <= in_mode;
        end
    end

    AST_HIDDEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && !s1_zero |-> s1_nm[NM_W-1]); // R4

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_mant == '0) |=> s1_zero && (s1_nm == '0)); // R11

endmodule

// File: rtl/fpn_round_pack.sv
module fpn_round_pack
    import fpn_pkg::*;
#(
    parameter int FRAC_W  = 23,
    parameter int EXP_W   = 8,
    parameter int GUARD_W = 2,
    parameter int EIN_W   = 10,
    localparam int NM_W   = 1 + FRAC_W + GUARD_W,
    localparam int ENW    = EIN_W + 1,
    localparam int EW2    = ENW + 2,
    localparam int RW     = FRAC_W + 2,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SH_W   = $clog2(NM_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s1_valid,
    input  logic                  s1_sign,
    input  logic                  s1_zero,
    input  logic signed [ENW-1:0] s1_exp,
    input  logic [NM_W-1:0]       s1_nm,
    input  logic                  s1_sticky,
    input  logic [1:0]            s1_mode,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_word
);

    localparam int BIAS_V  = (1 << (EXP_W - 1)) - 1;
    localparam int MAX_BE  = (1 << EXP_W) - 2;
    localparam logic signed [ENW-1:0] MIN_NORM_S = ENW'(1 - BIAS_V);
    localparam logic signed [ENW-1:0] MIN_DEN_S  = ENW'(1 - BIAS_V - FRAC_W);
    localparam logic signed [EW2-1:0] MAX_BE_S   = EW2'(MAX_BE);

    logic                  tiny, gone, lost, st, inexact, inc;
    logic signed [ENW-1:0] shortfall;
    logic [SH_W-1:0]       dsh;
    logic [NM_W-1:0]       dm;
    logic [RW-2:0]         ret;
    logic [GUARD_W-1:0]    g;
    logic [RW-1:0]         rr;
    logic signed [EW2-1:0] be;
    rclass_e               cls;
    logic [WORD_W-1:0]     word_n;

    // Denormal alignment
    always_comb begin
        tiny      = s1_exp < MIN_NORM_S;
        gone      = s1_exp < MIN_DEN_S;
        shortfall = MIN_NORM_S - s1_exp;
        dsh       = (tiny && !gone) ? shortfall[SH_W-1:0] : '0;
        dm        = s1_nm >> dsh;
        lost      = |(s1_nm & ~({NM_W{1'b1}} << dsh));
        st        = s1_sticky | lost;
        ret       = dm[NM_W-1:GUARD_W];
        g         = dm[GUARD_W-1:0];
        inexact   = (|g) | st;
    end

    // Rounding decision
    always_comb begin
        unique case (rmode_e'(s1_mode))
            RM_NEAR_EVEN: inc = g[GUARD_W-1] & (g[0] | st | ret[0]);
            RM_TO_ZERO:   inc = 1'b0;
            RM_UP:        inc = inexact & ~s1_sign;
            RM_DOWN:      inc = inexact &  s1_sign;
            default:      inc = 1'b0;
        endcase
        rr = {1'b0, ret} + RW'(inc);
        be = EW2'(s1_exp) + EW2'(BIAS_V) + EW2'(rr[RW-1]);
    end

    // Result class selection
    always_comb begin
        if (s1_zero || gone) begin
            cls = CLS_ZERO;
        end else if (tiny) begin
            cls = CLS_DENORM;
        end else if (be > MAX_BE_S) begin
            cls = CLS_INF;
        end else begin
            cls = CLS_NORMAL;
        end
    end

    // Packing per class
    always_comb begin
        unique case (cls)
            CLS_ZERO:   word_n = {s1_sign, {(WORD_W-1){1'b0}}};
            CLS_DENORM: word_n = {s1_sign, {(EXP_W-1){1'b0}}, rr[FRAC_W], rr[FRAC_W-1:0]};
            CLS_INF:    word_n = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            CLS_NORMAL: word_n = {s1_sign, be[EXP_W-1:0],
                                  rr[RW-1] ? rr[FRAC_W:1] : rr[FRAC_W-1:0]};
            default:    word_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_word <= word_n;
            end
        end
    end

    AST_INF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_word[WORD_W-2:FRAC_W] == {EXP_W{1'b1}})
        |-> (out_word[FRAC_W-1:0] == '0)); // R9

    AST_TOO_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && !s1_zero && (s1_exp < MIN_DEN_S)
        |=> (out_word[WORD_W-2:0] == '0)); // R11

    AST_TRUNC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && !s1_zero && (s1_mode == RM_TO_ZERO) && (s1_exp >= MIN_NORM_S)
        |=> (out_word[WORD_W-2:FRAC_W] == {EXP_W{1'b1}})
            || (out_word[FRAC_W-1:0] == $past(s1_nm[NM_W-2:GUARD_W]))); // R6

endmodule

// File: rtl/fp_norm_round_pack.sv
module fp_norm_round_pack
    import fpn_pkg::*;
#(
    parameter int P_FRAC_W  = FRAC_W,
    parameter int P_EXP_W   = EXP_W,
    parameter int P_HEAD_W  = HEAD_W,
    parameter int P_EIN_W   = EIN_W,
    localparam int MANT_W   = P_HEAD_W + 1 + P_FRAC_W + GUARD_W,
    localparam int NM_W     = 1 + P_FRAC_W + GUARD_W,
    localparam int ENW      = P_EIN_W + 1,
    localparam int WORD_W   = 1 + P_EXP_W + P_FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sign,
    input  logic signed [P_EIN_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic [1:0]              in_mode,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       out_word
);

    logic                  s1_valid, s1_sign, s1_zero, s1_sticky;
    logic signed [ENW-1:0] s1_exp;
    logic [NM_W-1:0]       s1_nm;
    logic [1:0]            s1_mode;

    fpn_norm #(
        .FRAC_W  (P_FRAC_W),
        .GUARD_W (GUARD_W),
        .HEAD_W  (P_HEAD_W),
        .EIN_W   (P_EIN_W)
    ) u_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sign   (in_sign),
        .in_exp    (in_exp),
        .in_mant   (in_mant),
        .in_mode   (in_mode),
        .s1_valid  (s1_valid),
        .s1_sign   (s1_sign),
        .s1_zero   (s1_zero),
        .s1_exp    (s1_exp),
        .s1_nm     (s1_nm),
        .s1_sticky (s1_sticky),
        .s1_mode   (s1_mode)
    );

    fpn_round_pack #(
        .FRAC_W  (P_FRAC_W),
        .EXP_W   (P_EXP_W),
        .GUARD_W (GUARD_W),
        .EIN_W   (P_EIN_W)
    ) u_rpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_sign   (s1_sign),
        .s1_zero   (s1_zero),
        .s1_exp    (s1_exp),
        .s1_nm     (s1_nm),
        .s1_sticky (s1_sticky),
        .s1_mode   (s1_mode),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2

    AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_mant == '0) |=> ##1 (out_word[WORD_W-2:0] == '0)); // R11

endmodule

// File: tb/fp_norm_round_pack_test.sv
`timescale 1ns/1ps
module fp_norm_round_pack_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sign = 1'b0;
    logic signed [9:0] in_exp = '0;
    logic [27:0]       in_mant = '0;
    logic [1:0]        in_mode = 2'b00;
    logic              out_valid;
    logic [31:0]       out_word;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fp_norm_round_pack uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sign   (in_sign),
        .in_exp    (in_exp),
        .in_mant   (in_mant),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // {sign, mode, exp, mant, expected word, requirement number}
    localparam int NV = 30;
    localparam logic [76:0] VEC [0:NV-1] = '{
        {1'b0, 2'd0,  10'sd3,   28'h3680000, 32'h415A0000, 4'd3},  // R3
        {1'b1, 2'd0, -10'sd3,   28'h2800000, 32'hBE200000, 4'd3},  // R3
        {1'b0, 2'd0,  10'sd7,   28'h0368000, 32'h415A0000, 4'd4},  // R4 left
        {1'b0, 2'd0,  10'sd2,   28'h6D00000, 32'h415A0000, 4'd4},  // R4 right 1
        {1'b0, 2'd0,  10'sd1,   28'hD000000, 32'h41500000, 4'd4},  // R4 right 2
        {1'b0, 2'd0,  10'sd0,   28'h2000002, 32'h3F800000, 4'd5},  // R5 tie even
        {1'b0, 2'd0,  10'sd0,   28'h2000006, 32'h3F800002, 4'd5},  // R5 tie odd
        {1'b0, 2'd0,  10'sd0,   28'h2000003, 32'h3F800001, 4'd5},  // R5 above half
        {1'b0, 2'd0,  10'sd0,   28'h2000001, 32'h3F800000, 4'd5},  // R5 below half
        {1'b0, 2'd0,  10'sd0,   28'h4000005, 32'h40000001, 4'd5},  // R5 tie+sticky
        {1'b0, 2'd0,  10'sd0,   28'h4000001, 32'h40000000, 4'd4},  // R4 sticky only
        {1'b0, 2'd1,  10'sd0,   28'h2000003, 32'h3F800000, 4'd6},  // R6
        {1'b1, 2'd1,  10'sd0,   28'h2000006, 32'hBF800001, 4'd6},  // R6
        {1'b0, 2'd2,  10'sd0,   28'h4000001, 32'h40000001, 4'd7},  // R7 up, sticky
        {1'b1, 2'd2,  10'sd0,   28'h2000003, 32'hBF800000, 4'd7},  // R7 up neg
        {1'b1, 2'd3,  10'sd0,   28'h2000003, 32'hBF800001, 4'd7},  // R7 down neg
        {1'b0, 2'd3,  10'sd0,   28'h2000003, 32'h3F800000, 4'd7},  // R7 down pos
        {1'b0, 2'd0,  10'sd0,   28'h3FFFFFF, 32'h40000000, 4'd8},  // R8 carry
        {1'b0, 2'd0,  10'sd127, 28'h2000000, 32'h7F000000, 4'd9},  // R9 max normal
        {1'b0, 2'd0,  10'sd128, 28'h2000000, 32'h7F800000, 4'd9},  // R9 inf
        {1'b0, 2'd0,  10'sd127, 28'h3FFFFFF, 32'h7F800000, 4'd8},  // R8 carry to inf
        {1'b0, 2'd1,  10'sd127, 28'h3FFFFFF, 32'h7F7FFFFF, 4'd9},  // R9 no carry
        {1'b1, 2'd1,  10'sd200, 28'h2000000, 32'hFF800000, 4'd9},  // R9 inf any mode
        {1'b0, 2'd0, -10'sd126, 28'h2000000, 32'h00800000, 4'd10}, // R10 min normal
        {1'b0, 2'd0, -10'sd127, 28'h2000000, 32'h00400000, 4'd10}, // R10
        {1'b0, 2'd0, -10'sd149, 28'h2000000, 32'h00000001, 4'd10}, // R10 min denorm
        {1'b0, 2'd2, -10'sd149, 28'h2000001, 32'h00000002, 4'd10}, // R10 sticky
        {1'b0, 2'd0, -10'sd127, 28'h3FFFFFF, 32'h00800000, 4'd10}, // R10 up to normal
        {1'b1, 2'd0, -10'sd150, 28'h2000000, 32'h80000000, 4'd11}, // R11 too small
        {1'b1, 2'd0,  10'sd50,  28'h0000000, 32'h80000000, 4'd11}  // R11 zero in
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [76:0] v);
        in_sign  = v[76];
        in_mode  = v[75:74];
        in_exp   = v[73:64];
        in_mant  = v[63:36];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({31'd0, out_valid}, 32'd1, int'(v[3:0]), "valid with result");
        check(out_word, v[35:4], int'(v[3:0]), "packed word");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({31'd0, out_valid}, 32'd0, 1, "valid in reset");      // R1
        check(out_word, 32'd0, 1, "word in reset");                 // R1
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({31'd0, out_valid}, 32'd0, 1, "valid idle after reset"); // R1
        check(out_word, 32'd0, 1, "word idle after reset");            // R1

        // R2 latency: one pulse, result exactly two edges later
        in_sign = 1'b0; in_mode = 2'b00; in_exp = 10'sd0; in_mant = 28'h2000000;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({31'd0, out_valid}, 32'd0, 2, "valid after one edge");
        @(negedge clk);
        check({31'd0, out_valid}, 32'd1, 2, "valid after two edges");
        check(out_word, 32'h3F800000, 2, "word after two edges");
        @(negedge clk);
        check({31'd0, out_valid}, 32'd0, 2, "valid after three edges");

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
        end

        // R2 back-to-back inputs
        in_mode = 2'b00; in_sign = 1'b0;
        in_exp = 10'sd3; in_mant = 28'h3680000; in_valid = 1'b1;
        @(negedge clk);
        in_exp = -10'sd3; in_mant = 28'h2800000; in_sign = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_word, 32'h415A0000, 2, "first of pair");
        @(negedge clk);
        check({31'd0, out_valid}, 32'd1, 2, "second of pair valid");
        check(out_word, 32'hBE200000, 2, "second of pair");
        @(negedge clk);
        check({31'd0, out_valid}, 32'd0, 2, "pair drained");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule